// File: doc/BRIEF.md
# Synchronised Gated Decade Counter

This block counts the rising edges of one selected input during exactly one period of a gating signal. A measurement has three phases. A clear empties the counters and returns the gate control to idle. A one-cycle arm pulse then primes the gate. The gate opens on the first rising gating edge after the arm and closes on the next rising gating edge. While the gate is open, each counted edge advances a chain of BCD decades. The carry out of the top decade advances a binary extension, which has a low part that wraps into a high part.

Two modes are available. In frequency mode the counted input is channel A or channel B, and the timebase input sets the gating window. In period mode the counted signal is an internal reference tick, made by dividing the system clock by a parameter, and channel A sets the gating window. All inputs are resampled into the system clock through a synchroniser before their rising edges are detected.

The gate control is a three-state machine:
- `ST_IDLE` is entered on reset or clear. It is also entered on the closing edge.
- `ST_PRIMED` is entered from `ST_IDLE` on arm.
- `ST_OPEN` is entered from `ST_PRIMED` on a gating edge.

The transitions are: IDLE→PRIMED on arm, PRIMED→OPEN on a gating edge, OPEN→IDLE on a gating edge, and any state→IDLE on clear. The done flag is high only in `ST_IDLE`.

Top module: `gcnt_gated_counter`

## Requirements
- R1: After reset, and in the cycle after a clear, the block is idle. `done_o` is 1, `gate_open_o` is 0, and `bcd_o` and `ext_o` are zero. Clear takes priority over every other input.
- R2: An arm pulse in the idle state moves the block to primed, so `done_o` reads 0 in the next cycle. An arm pulse while primed or open is ignored, and the gate stays open.
- R3: After arming, the gate stays closed until a rising edge of the gating signal arrives. It opens on the first such edge.
- R4: The next rising gating edge closes the gate. `gate_open_o` is therefore high for exactly one gating period, measured in system clock cycles.
- R5: `done_o` is 1 only when the block is neither primed nor open. It returns to 1 when the gate closes.
- R6: The count is held as BCD digits, and each digit stays within 0 to 9. Digit k sits in `bcd_o[4k+3:4k]`, with the units digit in bits 3:0. A digit advances when the digit below it rolls from 9 to 0. The units digit advances on each counted edge while the gate is open.
- R7: Each rollover of the top decade increments `ext_o`. `ext_o` = {high part, low part}, and a wrap of the low part increments the high part. Together they form one binary count of top-decade rollovers.
- R8: When `period_i`=0, `timebase_i` gates the count. With `sel_b_i`=0 the block counts edges of `chan_a_i`, and with `sel_b_i`=1 it counts edges of `chan_b_i`. The unselected channel has no effect on the result.
- R9: When `period_i`=1, the block counts reference ticks, one every REF_DIV clock cycles, and `chan_a_i` is the gating signal. `timebase_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the counters and the gate control |
| arm_i | input | 1 | One-cycle pulse that primes a measurement |
| period_i | input | 1 | 1 selects period mode, 0 selects frequency mode |
| sel_b_i | input | 1 | In frequency mode, 1 counts channel B and 0 counts channel A |
| chan_a_i | input | 1 | Channel A input |
| chan_b_i | input | 1 | Channel B input, already prescaled |
| timebase_i | input | 1 | Gating signal for frequency mode |
| done_o | output | 1 | High while idle, meaning the measurement is complete |
| gate_open_o | output | 1 | High while counting is enabled |
| bcd_o | output | 16 | Four BCD digits, units digit lowest |
| ext_o | output | 24 | Binary extension above the decades |

## Verification
The main function is tried with four input patterns:
- Channel A is counted against a short timebase window, which gives a count of 100.
- Channel B is counted while channel A toggles at a different rate. The expected count of 1234 separates the two channel selections.
- A fast channel A is counted over a long window. The count goes past several decade rollovers and past a wrap of the extension's low part.
- In period mode, reference ticks are counted over one channel A period while the timebase is active. This shows the timebase is ignored.

Two further runs cover the gate control. In the first, the timebase is held still after arming, which shows the gate does not open before a gating edge. In the second, a clear is issued while the gate is open, which shows that clear cancels a measurement in progress. The gate-open time is measured in clock cycles and compared with the gating period.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIMED = 2'd1,
        ST_OPEN   = 2'd2
    } gate_state_t;
endpackage

// File: rtl/gcnt_edge_sync.sv
module gcnt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    // STAGES synchroniser flops, plus one history flop for edge detection.
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], din};
        end
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/gcnt_gate_ctrl.sv
module gcnt_gate_ctrl
    import gcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic arm_i,
    input  logic gate_edge_i,
    output logic prime_o,
    output logic gate_o,
    output logic done_o
);
    gate_state_t state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arm_i)       state_d = ST_PRIMED;
            ST_PRIMED: if (gate_edge_i) state_d = ST_OPEN;
            ST_OPEN:   if (gate_edge_i) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
        if (clear_i) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        prime_o = 1'b0;
        gate_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   done_o  = 1'b1;
            ST_PRIMED: prime_o = 1'b1;
            ST_OPEN:   gate_o  = 1'b1;
            default:   done_o  = 1'b1;
        endcase
    end

    p_arm_primes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && done_o && !clear_i |=> !done_o && !gate_o);

    p_open_after_prime_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(prime_o) && $past(gate_edge_i));

    p_close_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o && gate_edge_i |=> done_o);

    p_done_after_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o) |-> done_o);
endmodule

// File: rtl/gcnt_decade_chain.sv
module gcnt_decade_chain
    import gcnt_pkg::*;
#(
    parameter int NUM_DEC  = 4,
    parameter int EXT_LO_W = 16,
    parameter int EXT_HI_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          inc_i,
    output logic [NUM_DEC*DIGIT_W-1:0]    bcd_o,
    output logic [EXT_LO_W+EXT_HI_W-1:0]  ext_o
);
    localparam logic [DIGIT_W-1:0] DIG_MAX = DIGIT_W'(9);

    logic [NUM_DEC:0] carry;
    assign carry[0] = inc_i;

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        logic [DIGIT_W-1:0] dig_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig_q <= '0;
            end else if (clear_i) begin
                dig_q <= '0;
            end else if (carry[g]) begin
                dig_q <= (dig_q == DIG_MAX) ? '0 : dig_q + 1'b1;
            end
        end

        assign carry[g+1] = carry[g] & (dig_q == DIG_MAX);
        assign bcd_o[g*DIGIT_W +: DIGIT_W] = dig_q;

        p_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q <= DIG_MAX);
    end

    logic [EXT_LO_W-1:0] lo_q;
    logic [EXT_HI_W-1:0] hi_q;
    logic                lo_wrap;

    assign lo_wrap = carry[NUM_DEC] & (&lo_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (clear_i) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (carry[NUM_DEC]) lo_q <= lo_q + 1'b1;
            if (lo_wrap)        hi_q <= hi_q + 1'b1;
        end
    end

    assign ext_o = {hi_q, lo_q};

    p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !carry[NUM_DEC] && !clear_i |=> $stable(ext_o));

    p_bcd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i && !clear_i |=> $stable(bcd_o));
endmodule

// File: rtl/gcnt_gated_counter.sv
module gcnt_gated_counter
    import gcnt_pkg::*;
#(
    parameter int NUM_DEC     = 4,
    parameter int EXT_LO_W    = 16,
    parameter int EXT_HI_W    = 8,
    parameter int REF_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         arm_i,
    input  logic                         period_i,
    input  logic                         sel_b_i,
    input  logic                         chan_a_i,
    input  logic                         chan_b_i,
    input  logic                         timebase_i,
    output logic                         done_o,
    output logic                         gate_open_o,
    output logic [NUM_DEC*DIGIT_W-1:0]   bcd_o,
    output logic [EXT_LO_W+EXT_HI_W-1:0] ext_o
);
    localparam int REF_CW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam logic [REF_CW-1:0] REF_LAST = REF_CW'(REF_DIV - 1);
    localparam int N_IN = 3;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_T = 2;

    // Reference tick generator for period mode.
    logic [REF_CW-1:0] ref_q;
    logic              ref_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else begin
            ref_q <= (ref_q == REF_LAST) ? '0 : ref_q + 1'b1;
        end
    end

    assign ref_tick = (ref_q == REF_LAST);

    // Resample every external input and detect its rising edges.
    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;

    assign raw_in = {timebase_i, chan_b_i, chan_a_i};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        gcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (raw_in[i]),
            .rise_o (rise[i])
        );
    end

    // Pick the counted source and the gating source for the mode.
    logic cnt_edge, gate_edge, prime, gate, done;

    always_comb begin
        if (period_i) begin
            cnt_edge  = ref_tick;
            gate_edge = rise[IDX_A];
        end else begin
            cnt_edge  = sel_b_i ? rise[IDX_B] : rise[IDX_A];
            gate_edge = rise[IDX_T];
        end
    end

    gcnt_gate_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .arm_i       (arm_i),
        .gate_edge_i (gate_edge),
        .prime_o     (prime),
        .gate_o      (gate),
        .done_o      (done)
    );

    gcnt_decade_chain #(
        .NUM_DEC  (NUM_DEC),
        .EXT_LO_W (EXT_LO_W),
        .EXT_HI_W (EXT_HI_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .inc_i   (gate & cnt_edge),
        .bcd_o   (bcd_o),
        .ext_o   (ext_o)
    );

    assign done_o      = done;
    assign gate_open_o = gate;

    p_one_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prime, gate}) && (done == !(prime | gate)));

    p_closed_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate && !clear_i |=> $stable(bcd_o));
endmodule

// File: tb/gcnt_gated_counter_test.sv
`timescale 1ns/1ps
module gcnt_gated_counter_test;
    localparam int EXT_LO = 1;
    localparam int EXT_HI = 8;
    localparam int EXT_W  = EXT_LO + EXT_HI;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0, arm_i = 1'b0, period_i = 1'b0, sel_b_i = 1'b0;
    logic chan_a = 1'b0, chan_b = 1'b0, tbase = 1'b0;
    logic done_o, gate_open_o;
    logic [15:0] bcd_o;
    logic [EXT_W-1:0] ext_o;

    int errors = 0;
    int checks = 0;
    int ha = 0, hb = 0, ht = 0;   // half periods in clock cycles, 0 = hold
    int win_cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gcnt_gated_counter #(.EXT_LO_W(EXT_LO), .EXT_HI_W(EXT_HI)) uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .arm_i(arm_i),
        .period_i(period_i), .sel_b_i(sel_b_i), .chan_a_i(chan_a),
        .chan_b_i(chan_b), .timebase_i(tbase), .done_o(done_o),
        .gate_open_o(gate_open_o), .bcd_o(bcd_o), .ext_o(ext_o)
    );

    // Input waveform generators.
    always begin
        if (ha == 0) @(posedge clk);
        else begin repeat (ha) @(posedge clk); chan_a <= ~chan_a; end
    end
    always begin
        if (hb == 0) @(posedge clk);
        else begin repeat (hb) @(posedge clk); chan_b <= ~chan_b; end
    end
    always begin
        if (ht == 0) @(posedge clk);
        else begin repeat (ht) @(posedge clk); tbase <= ~tbase; end
    end

    // Count the cycles for which the gate is open.
    always @(negedge clk) if (gate_open_o) win_cycles <= win_cycles + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int to_bcd(input int n);
        int r = 0;
        int v = n % 10000;
        for (int k = 0; k < 4; k++) begin
            r = r | ((v % 10) << (4 * k));
            v = v / 10;
        end
        return r;
    endfunction

    task automatic pulse_clear();
        @(negedge clk) clear_i = 1'b1;
        @(negedge clk) clear_i = 1'b0;
    endtask

    task automatic pulse_arm();
        @(negedge clk) arm_i = 1'b1;
        @(negedge clk) arm_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_o && n < 60000) begin @(negedge clk); n++; end
        if (!done_o) check({req, " watchdog"}, 0, 1);
    endtask

    task automatic wait_open(input string req);
        int n = 0;
        while (!gate_open_o && n < 60000) begin @(negedge clk); n++; end
        if (!gate_open_o) check({req, " gate never opened"}, 0, 1);
    endtask

    // Runs one measurement: clear, arm, re-arm while open, wait for the result.
    task automatic measure(input string req, input int cnt, input int window);
        pulse_clear();
        check({req, " R1 idle after clear"}, int'(done_o), 1);
        check({req, " R1 bcd zero after clear"}, int'(bcd_o), 0);
        win_cycles = 0;
        pulse_arm();
        check({req, " R2 done low after arm"}, int'(done_o), 0);
        wait_open(req);
        pulse_arm();
        if (window > 3) check({req, " R2 arm ignored while open"}, int'(gate_open_o), 1);
        wait_done(req);
        @(negedge clk);
        check({req, " R4 gate window cycles"}, win_cycles, window);
        check({req, " R6 bcd result"}, int'(bcd_o), to_bcd(cnt));
        check({req, " R7 ext result"}, int'(ext_o), cnt / 10000);
    endtask

    task automatic t_reset();
        check("R1 reset done", int'(done_o), 1);
        check("R1 reset gate", int'(gate_open_o), 0);
        check("R1 reset bcd", int'(bcd_o), 0);
        check("R1 reset ext", int'(ext_o), 0);
    endtask

    task automatic t_freq_a();
        period_i = 1'b0; sel_b_i = 1'b0; ha = 2; hb = 3; ht = 200;
        measure("R8 chan A", 100, 400);
    endtask

    task automatic t_freq_b();
        period_i = 1'b0; sel_b_i = 1'b1; ha = 2; hb = 3; ht = 3702;
        measure("R8 chan B", 1234, 7404);
    endtask

    task automatic t_ext();
        period_i = 1'b0; sel_b_i = 1'b0; ha = 1; hb = 0; ht = 21234;
        measure("R7 extension", 21234, 42468);
    endtask

    task automatic t_period();
        period_i = 1'b1; sel_b_i = 1'b0; ha = 400; hb = 0; ht = 7;
        measure("R9 period", 100, 800);
    endtask

    task automatic t_hold_closed();
        period_i = 1'b0; sel_b_i = 1'b0; ha = 2; ht = 0;
        pulse_clear();
        pulse_arm();
        repeat (50) @(negedge clk);
        check("R3 gate closed without gating edge", int'(gate_open_o), 0);
        check("R5 done low while primed", int'(done_o), 0);
        check("R3 no count while primed", int'(bcd_o), 0);
        ht = 100;
        wait_open("R3");
        check("R3 gate opens on gating edge", int'(gate_open_o), 1);
        wait_done("R5");
        @(negedge clk);
        check("R5 done after close", int'(done_o), 1);
        check("R8 count after delayed open", int'(bcd_o), to_bcd(50));
    endtask

    task automatic t_clear_mid();
        period_i = 1'b0; sel_b_i = 1'b0; ha = 2; ht = 2000;
        pulse_clear();
        pulse_arm();
        wait_open("R1 mid");
        repeat (100) @(negedge clk);
        pulse_clear();
        check("R1 clear closes gate", int'(gate_open_o), 0);
        check("R1 clear sets done", int'(done_o), 1);
        check("R1 clear zeros bcd", int'(bcd_o), 0);
        check("R1 clear zeros ext", int'(ext_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold_closed();
        t_freq_a();
        t_freq_b();
        t_ext();
        t_period();
        t_clear_mid();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule